// File: doc/BRIEF.md
# Receive FIFO with Level and Idle Interrupt

This block holds received bytes from an asynchronous serial receiver until a host reads them. A mode bit selects an 8-entry or a 16-entry queue. The block raises a level-sensitive receiver interrupt when the number of bytes held reaches a threshold. The threshold is picked by a 2-bit code, and that code is assembled from two separate mode bits.

An optional idle watchdog counts receiver 1X bit-time ticks while unread data sits in the queue. If 64 ticks pass with no push and no read, it raises the interrupt. This catches a short tail of a message that never reaches the threshold. A byte pushed into a full queue is lost, and a sticky overrun flag records the loss until a clear strobe removes it.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset the queue is empty, and `rdy`, `full`, `ovr` and `irq` are all 0.
- R2: Bytes leave in arrival order. `rd_data` always shows the oldest held byte, and `pop` removes it. A `pop` while empty changes nothing.
- R3: `size16`=0 gives a depth of 8 and `size16`=1 gives a depth of 16. `full` is 1 exactly when the count equals the depth, and `rdy` is 1 when the count is not zero.
- R4: A `push` while `full` is 1 drops the byte and sets `ovr`. This holds even when a `pop` comes in the same cycle. `ovr` stays set until `ovr_clr`, and a new overrun in the same cycle as `ovr_clr` wins.
- R5: At depth 8, the code {`lvl_hi`,`lvl_lo`} = 00, 01, 10, 11 raises the threshold condition at a count of at least 1, 3, 6 or 8 bytes.
- R6: At depth 16, the codes 00, 01, 10, 11 raise the threshold condition at a count of at least 1, 8, 12 or 16 bytes.
- R7: With `wd_en`=1 and the queue not empty, the watchdog condition sets after 64 `bit_tick` pulses with no `push` or `pop` in between. It stays set until the next `pop` that removes a byte.
- R8: Any `push` or `pop` restarts the tick count. No counting happens while the queue is empty or while `wd_en`=0, and `wd_en`=0 also clears the watchdog condition.
- R9: A change of `size16` empties the queue and restarts the watchdog on the next clock edge, and that cycle's `push` and `pop` are ignored. `ovr` is not affected.
- R10: `irq` is the OR of the threshold condition and the watchdog condition, held as a level. `irq` is 0 whenever the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Receiver byte strobe |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Host read strobe |
| size16 | input | 1 | Depth select: 0 = 8, 1 = 16 |
| lvl_hi | input | 1 | High bit of the threshold code |
| lvl_lo | input | 1 | Low bit of the threshold code |
| wd_en | input | 1 | Idle watchdog enable |
| bit_tick | input | 1 | One pulse per receiver 1X bit time |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest held byte |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Queue holds depth bytes |
| ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receiver interrupt, level |

## Verification
The bench steps through every threshold code at both depths, one byte at a time. A wrong threshold table or a mode mix-up shows up as `irq` rising one or more bytes early or late. It sweeps the watchdog to 63 and 64 ticks, and again after a mid-window push. A counter that is off by one, or one that ignores restarts, fires one tick early or stays silent. It also checks that ticks on an empty queue or with the watchdog disabled never accumulate into a later early fire. The overrun case confirms that the ninth byte is really discarded, so the queue contents stay intact. It also checks the set-over-clear priority, and that a depth switch leaves nothing readable.

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DW        = 8,
  parameter int DEPTH_MAX = 16,
  parameter int WD_TICKS  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          size16,
  input  logic          lvl_hi,
  input  logic          lvl_lo,
  input  logic          wd_en,
  input  logic          bit_tick,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          full,
  output logic          ovr,
  output logic          irq
);
  localparam int AW  = $clog2(DEPTH_MAX);
  localparam int CW  = AW + 1;
  localparam int WW  = $clog2(WD_TICKS);
  localparam int LOD = DEPTH_MAX / 2;

  logic [DW-1:0] mem [DEPTH_MAX];
  logic [AW-1:0] wp, rp, last;
  logic [CW-1:0] cnt, depth, thr;
  logic [WW-1:0] wdc;
  logic          size_q, wd_flag, ovr_q;
  logic          flush, do_push, do_pop;

  assign flush   = size16 != size_q;
  assign depth   = size_q ? CW'(DEPTH_MAX) : CW'(LOD);
  assign last    = size_q ? AW'(DEPTH_MAX - 1) : AW'(LOD - 1);
  assign full    = cnt == depth;
  assign rdy     = cnt != '0;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && rdy && !flush;
  assign rd_data = mem[rp];
  assign ovr     = ovr_q;

  always_comb begin
    case ({lvl_hi, lvl_lo})
      2'b00:   thr = CW'(1);
      2'b01:   thr = size_q ? CW'(DEPTH_MAX / 2) : CW'((3 * LOD) / 8);
      2'b10:   thr = size_q ? CW'((3 * DEPTH_MAX) / 4) : CW'((3 * LOD) / 4);
      default: thr = depth;
    endcase
  end

  assign irq = (cnt >= thr) || wd_flag;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; size_q <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0; size_q <= size16;
    end else begin
      if (do_push) wp <= (wp == last) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == last) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdc <= '0; wd_flag <= 1'b0;
    end else if (flush || !wd_en) begin
      wdc <= '0; wd_flag <= 1'b0;
    end else if (push || pop) begin
      wdc <= '0;
      if (do_pop) wd_flag <= 1'b0;
    end else if (bit_tick && rdy && !wd_flag) begin
      if (wdc == WW'(WD_TICKS - 1)) begin
        wd_flag <= 1'b1;
        wdc     <= '0;
      end else begin
        wdc <= wdc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovr_q <= 1'b0;
    else if (push && full && !flush)  ovr_q <= 1'b1;
    else if (ovr_clr)                 ovr_q <= 1'b0;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= depth);
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> ovr);
  // R4
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(push && full && !flush)) |=> !ovr);
  // R7
  wd_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rdy && !flush) |=> !wd_flag);
  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size16 != size_q) |=> !rdy);
  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> !irq);
endmodule

// File: tb/tb_rx_fifo_irq.sv
module tb_rx_fifo_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 0, pop = 0, size16 = 0, lvl_hi = 0, lvl_lo = 0;
  logic wd_en = 0, bit_tick = 0, ovr_clr = 0;
  logic [7:0] push_data = '0, rd_data;
  logic rdy, full, ovr, irq;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  rx_fifo_irq dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_push(logic [7:0] b);
    @(negedge clk) begin push = 1; push_data = b; end
    @(negedge clk) push = 0;
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1;
    @(negedge clk) pop = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) if (rdy) do_pop();
  endtask

  task automatic set_mode(logic s, logic [1:0] code);
    @(negedge clk) begin size16 = s; {lvl_hi, lvl_lo} = code; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 0); chk("R1 full", full, 0);
    chk("R1 ovr", ovr, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_order();
    set_mode(0, 2'b11);
    for (int i = 0; i < 5; i++) do_push(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      chk("R2 order", rd_data, 8'hA0 + 8'(i));
      do_pop();
    end
    chk("R3 rdy empty", rdy, 0);
    do_pop();
    do_push(8'h5C);
    chk("R2 pop-empty ignored data", rd_data, 8'h5C);
    do_pop();
    chk("R2 pop-empty ignored count", rdy, 0);
  endtask

  task automatic t_thr(logic s);
    int t8[4]  = '{1, 3, 6, 8};
    int t16[4] = '{1, 8, 12, 16};
    for (int c = 0; c < 4; c++) begin
      drain();
      set_mode(s, 2'(c));
      for (int n = 1; n <= (s ? 16 : 8); n++) begin
        do_push(8'(n));
        if (s) chk("R6 R10 thr16", irq, n >= t16[c]);
        else   chk("R5 R10 thr8", irq, n >= t8[c]);
        chk("R3 full", full, n == (s ? 16 : 8));
      end
    end
    drain();
  endtask

  task automatic t_ovr();
    set_mode(0, 2'b11);
    drain();
    for (int i = 0; i < 8; i++) do_push(8'h10 + 8'(i));
    chk("R3 full8", full, 1);
    chk("R4 no ovr yet", ovr, 0);
    @(negedge clk) begin push = 1; pop = 1; push_data = 8'hEE; end
    @(negedge clk) begin push = 0; pop = 0; end
    chk("R4 ovr set", ovr, 1);
    for (int i = 1; i < 8; i++) begin
      chk("R4 dropped byte absent", rd_data, 8'h10 + 8'(i));
      do_pop();
    end
    chk("R4 empty after", rdy, 0);
    chk("R4 sticky", ovr, 1);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    chk("R4 clear", ovr, 0);
    for (int i = 0; i < 8; i++) do_push(8'(i));
    @(negedge clk) begin push = 1; ovr_clr = 1; end
    @(negedge clk) begin push = 0; ovr_clr = 0; end
    chk("R4 set wins", ovr, 1);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    drain();
  endtask

  task automatic t_flush();
    set_mode(1, 2'b11);
    for (int i = 0; i < 5; i++) do_push(8'h30 + 8'(i));
    chk("R9 held before", rdy, 1);
    set_mode(0, 2'b11);
    chk("R9 flushed", rdy, 0);
    chk("R9 ovr kept", ovr, 0);
    do_push(8'h77);
    chk("R9 fresh data", rd_data, 8'h77);
    drain();
  endtask

  task automatic t_wd();
    set_mode(0, 2'b11);
    @(negedge clk) wd_en = 1;
    do_push(8'h01);
    ticks(63);
    chk("R7 63 ticks quiet", irq, 0);
    ticks(1);
    chk("R7 R10 64 ticks fire", irq, 1);
    do_pop();
    chk("R7 pop clears", irq, 0);
    do_push(8'h02);
    ticks(40);
    do_push(8'h03);
    ticks(40);
    chk("R8 push restarts", irq, 0);
    ticks(24);
    chk("R8 fire after restart", irq, 1);
    do_pop();
    chk("R7 cleared again", irq, 0);
    @(negedge clk) wd_en = 0;
    ticks(70);
    chk("R8 disabled", irq, 0);
    @(negedge clk) wd_en = 1;
    drain();
    ticks(70);
    do_push(8'h04);
    ticks(63);
    chk("R8 no count while empty", irq, 0);
    ticks(1);
    chk("R8 fire after empty", irq, 1);
    drain();
    @(negedge clk) wd_en = 0;
  endtask

  initial begin
    #(200000 * 8);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_thr(0);
    t_thr(1);
    t_ovr();
    t_flush();
    t_wd();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule